// File: doc/BRIEF.md
# Packed Sum of Absolute Differences Unit

This unit takes two 32-bit words. Each word holds four unsigned 8-bit pixels. The unit returns the sum of the absolute differences between matching pixels. When requested, it also adds a 32-bit accumulator to that sum. A motion-estimation engine streams candidate and reference pixel groups into it. The unit accepts one 4-pixel group per clock and returns results in the order the groups arrived.

The pipeline has two stages. The first stage computes the absolute difference of each lane. The second stage adds the lanes together and applies the accumulator. The accumulator can come from an input port. It can also come from the unit's own most recent result, so a running total can build up with no round trip outside the unit.

Both streams use valid/ready. An input word transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on a clock edge where `out_valid` and `out_ready` are both high. While a result is held back (`out_valid` high, `out_ready` low), the whole pipeline freezes and `in_ready` is low. The held result and its valid stay unchanged. `in_ready` depends only on `out_valid` and `out_ready`.

Top module: `packed_sad_unit`

## Requirements
- R1: Lane i of each operand is bits [8i+7:8i], treated as unsigned. The result is the sum over the four lanes of |a_i - b_i|. It is correct when a lane of `in_a` is below, equal to or above the matching lane of `in_b`.
- R2: With `in_acc_en` = 0, `out_result` is that sum zero-extended to 32 bits. It is never above 1020.
- R3: With `in_acc_en` = 1 and `in_acc_last` = 0, `out_result` = sum + `in_acc`.
- R4: The accumulate addition wraps modulo 2^32.
- R5: With `in_acc_en` = 1 and `in_acc_last` = 1, the accumulator is the result of the operation just before this one in stream order, and `in_acc` is ignored. This holds even when the two operations are back to back. After reset the previous result counts as 0.
- R6: With `in_acc_en` = 0, both `in_acc` and `in_acc_last` have no effect on the result.
- R7: When `out_ready` is held high, `in_ready` stays high. A result appears two clock edges after its input is accepted, and the unit sustains one result per cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold and `in_ready` is low. No result is lost, duplicated or reordered.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit can accept an input word |
| in_a | input | 32 | Four packed unsigned pixels, operand A |
| in_b | input | 32 | Four packed unsigned pixels, operand B |
| in_acc | input | 32 | External accumulator value |
| in_acc_en | input | 1 | 1: add an accumulator to the sum |
| in_acc_last | input | 1 | 1: accumulator is the previous result instead of `in_acc` |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 32 | Sum of absolute differences, with the accumulator if selected |

## Verification
Each result is due two clock edges after its input is accepted, as long as `out_ready` stays high. Any stall adds exactly the cycles spent frozen. The bench drives inputs and `out_ready` on the falling edge. It notes the cycle count just before each accepting edge. The scoreboard monitor samples a few nanoseconds after a falling edge, and during the unstalled phase it checks that each result arrives exactly two counts later. In the randomized back-pressure phase only order and value are compared. Expected values for the previous-result chains are built in the order items are pushed, which matches the order results come out.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PREV = 2'd2
  } acc_src_e;

  function automatic acc_src_e decode_src(input logic en, input logic last);
    if (!en)  return SRC_NONE;
    if (last) return SRC_PREV;
    return SRC_EXT;
  endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] absd
);
  logic [W:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    absd = diff[W] ? W'(-diff) : diff[W-1:0];
  end

  // R1
  always_comb begin
    if (a >= b) lane_abs_chk_hi: assert ((absd + b) == a);
    else        lane_abs_chk_lo: assert ((absd + a) == b);
  end
endmodule

// File: rtl/sad_stage2.sv
module sad_stage2
  import sad_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic                 s1_valid,
  input  logic [LANES*W-1:0]   s1_absd,
  input  acc_src_e             s1_src,
  input  logic [ACC_W-1:0]     s1_acc,
  output logic                 out_valid,
  output logic [ACC_W-1:0]     result
);
  localparam int SUM_W = W + $clog2(LANES);

  logic [SUM_W-1:0] lane_sum;
  logic [ACC_W-1:0] acc_term;
  logic [ACC_W-1:0] next_result;

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++)
      lane_sum = lane_sum + SUM_W'(s1_absd[i*W +: W]);
  end

  always_comb begin
    unique case (s1_src)
      SRC_EXT:  acc_term = s1_acc;
      SRC_PREV: acc_term = result;
      default:  acc_term = '0;
    endcase
    next_result = acc_term + ACC_W'(lane_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) result <= next_result;
    end
  end

  // R2
  sum_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && s1_valid && s1_src == SRC_NONE) |=> (result[ACC_W-1:SUM_W] == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(result) && $stable(out_valid)));
endmodule

// File: rtl/packed_sad_unit.sv
module packed_sad_unit
  import sad_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES*W-1:0]   in_a,
  input  logic [LANES*W-1:0]   in_b,
  input  logic [ACC_W-1:0]     in_acc,
  input  logic                 in_acc_en,
  input  logic                 in_acc_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ACC_W-1:0]     out_result
);
  localparam int OP_W = LANES * W;

  logic             advance;
  logic [OP_W-1:0]  absd_c;
  logic             s1_valid;
  logic [OP_W-1:0]  s1_absd;
  acc_src_e         s1_src;
  logic [ACC_W-1:0] s1_acc;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sad_lane #(.W(W)) u_lane (
      .a    (in_a[g*W +: W]),
      .b    (in_b[g*W +: W]),
      .absd (absd_c[g*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_absd  <= '0;
      s1_src   <= SRC_NONE;
      s1_acc   <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_absd <= absd_c;
        s1_src  <= decode_src(in_acc_en, in_acc_last);
        s1_acc  <= in_acc;
      end
    end
  end

  sad_stage2 #(.LANES(LANES), .W(W), .ACC_W(ACC_W)) u_stage2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .s1_valid  (s1_valid),
    .s1_absd   (s1_absd),
    .s1_src    (s1_src),
    .s1_acc    (s1_acc),
    .out_valid (out_valid),
    .result    (out_result)
  );

  // R7
  accept_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);

  // R8
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: tb/packed_sad_unit_tb.sv
module packed_sad_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0, in_acc = '0;
  logic        in_acc_en = 1'b0, in_acc_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  always #10 clk = ~clk;

  packed_sad_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_acc_en(in_acc_en),
    .in_acc_last(in_acc_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  typedef struct {
    logic [31:0] val;
    string       req;
    bit          chk_lat;
    int          acc_cyc;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [31:0] last_exp = '0;
  bit          bp_mode = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                      input bit en, input bit last, input string req, input bit lat);
    logic [31:0] sum;
    logic [31:0] exp;
    item_t it;
    bit ok;
    int c;
    sum = 0;
    for (int i = 0; i < 4; i++)
      sum += (a[i*8 +: 8] > b[i*8 +: 8]) ? 32'(a[i*8 +: 8] - b[i*8 +: 8])
                                          : 32'(b[i*8 +: 8] - a[i*8 +: 8]);
    exp = en ? ((last ? last_exp : acc) + sum) : sum;
    last_exp = exp;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_acc = acc;
    in_acc_en = en; in_acc_last = last;
    forever begin
      #5;
      ok = in_ready;
      c = cyc;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    it.val = exp; it.req = req; it.chk_lat = lat; it.acc_cyc = c;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready driver: random during back-pressure phase
  always @(negedge clk) out_ready <= bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;

  // scoreboard monitor
  always begin
    @(negedge clk);
    #3;
    if (rst_n && out_valid && !out_ready)
      check(in_ready == 1'b0, "R8 in_ready low while stalled", 32'(in_ready), 32'd0);
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected result", out_result, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(out_result == it.val, it.req, out_result, it.val);
        if (it.chk_lat)
          check(cyc == it.acc_cyc + 2, "R7 latency of two edges", 32'(cyc - it.acc_cyc), 32'd2);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(out_valid == 1'b0, "R9 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R9 in_ready after reset", 32'(in_ready), 32'd1);

    // unstalled phase: latency and values
    send(32'h0a0b0c0d, 32'h01020304, 32'd777, 1, 1, "R5 previous result is 0 after reset", 1);
    send(32'h10203040, 32'h10203040, 32'd0, 0, 0, "R1 equal lanes", 1);
    send(32'hffffffff, 32'h00000000, 32'd0, 0, 0, "R2 maximum sum 1020", 1);
    send(32'h00000000, 32'hffffffff, 32'd0, 0, 0, "R1 b above a in every lane", 1);
    send(32'h80017f05, 32'h7f02800a, 32'd0, 0, 0, "R1 mixed lane order", 1);
    send(32'h11223344, 32'h44332211, 32'd12345, 0, 1, "R6 acc inputs ignored without enable", 1);
    send(32'h01010101, 32'h00000000, 32'd1000, 1, 0, "R3 external accumulate", 1);
    send(32'hffffffff, 32'h00000000, 32'hffffffff, 1, 0, "R4 accumulate wraps", 1);
    send(32'h05050505, 32'h00000000, 32'd9, 1, 1, "R5 back-to-back previous result", 1);
    send(32'h00000003, 32'h00000000, 32'd9, 1, 1, "R5 chained previous result", 1);
    send(32'h00ff0000, 32'h00000000, 32'd9, 1, 1, "R5 chained previous result", 1);
    idle();
    repeat (3) @(posedge clk);
    send(32'h00000001, 32'h00000000, 32'd55, 1, 1, "R5 previous result after gap", 1);
    idle();
    repeat (4) @(posedge clk);

    // back-pressure phase
    bp_mode = 1'b1;
    for (int n = 0; n < 60; n++) begin
      bit en;
      bit last;
      en = ($urandom_range(0, 1) == 1);
      last = ($urandom_range(0, 1) == 1);
      send($urandom, $urandom, $urandom, en, last, "R8 value under back-pressure", 0);
      if ($urandom_range(0, 4) == 0) begin
        idle();
        @(posedge clk);
      end
    end
    idle();
    bp_mode = 1'b0;
    for (int w = 0; w < 50 && sb.size() != 0; w++) @(posedge clk);
    #1;
    check(sb.size() == 0, "R8 all results delivered", 32'(sb.size()), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule